// File: doc/BRIEF.md
# Microscaled FP4 Block Dot Product

This block takes two blocks of 32 four-bit floating-point elements (one sign bit, two exponent bits, one mantissa bit). Each block carries its own 8-bit power-of-two scale. The block returns their dot product as an IEEE single-precision number. A typical pairing is one block of weights against one block of activations. No element is widened to a higher-precision float. Each element is read as an exact small integer in half units, and each pair is multiplied into an exact quarter-unit product. The 32 products are summed in fixed point with no rounding. The two block scales are then applied together, once, as an exponent offset while the sum is packed into FP32.

Operand pairs enter under a valid/ready handshake. Results leave under a second valid/ready handshake, in the order the pairs were accepted. The pipeline is two register stages deep. When the output is not taken, the whole pipeline stalls and the input stops accepting.

Top module: `mxdot_block`

## Requirements
- R1: Element i of a block occupies bits [4i+3:4i]. Within an element, bit 3 is the sign, bits 2:1 are the exponent field and bit 0 is the mantissa bit. Codes 0..7 have magnitudes 0, 0.5, 1, 1.5, 2, 3, 4, 6, and code 8 (negative zero) reads as zero.
- R2: The result equals (sum over i of a_i*b_i) * 2^(sa-127) * 2^(sb-127), where sa and sb are the 8-bit scale codes. The sum is formed exactly.
- R3: A nonzero in-range result is packed as normalized FP32 with round to nearest even. Because the exact sum always fits the 24-bit significand, no rounding step ever changes the value.
- R4: If either scale code is 0xFF, the result is the quiet NaN 0x7FC00000, whatever the elements are.
- R5: An exact zero sum with valid scales gives +0.0 (0x00000000), including when nonzero products cancel.
- R6: A result whose biased FP32 exponent would reach 255 or more becomes infinity with the sum's sign (0x7F800000 or 0xFF800000).
- R7: A result whose biased FP32 exponent would be 0 or less is flushed to a zero carrying the sum's sign. No subnormal is ever produced.
- R8: With out_ready held high, a pair accepted at clock edge k appears on out_result with out_valid high after edge k+1. That is a latency of MXDOT_LATENCY = 2, and in_ready stays high.
- R9: While out_valid is high and out_ready low, out_result and out_valid hold. At most two pairs are held inside, in_ready drops, and all results leave in acceptance order.
- R10: After synchronous reset, out_valid is low and no result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| a_elems | input | 128 | First block, 32 packed 4-bit elements |
| a_scale | input | 8 | Shared scale code of the first block |
| b_elems | input | 128 | Second block, 32 packed 4-bit elements |
| b_scale | input | 8 | Shared scale code of the second block |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | FP32 dot product |

## Verification
A pair accepted at edge k has its FP32 result due just after edge k+1 when out_ready is high. Each scenario drives inputs at falling edges. It samples once at the falling edge after the accept edge, where out_valid must still be low, and again one edge later, where the exact bit pattern is compared. In the stall scenario out_ready is held low. The checks at each falling edge confirm that the first result stays frozen and that in_ready is low once two pairs are inside. When the stall is released, results are compared one per falling edge against a queue in acceptance order.

// File: rtl/mxdot_pkg.sv
package mxdot_pkg;
  localparam int ELEM_W        = 4;
  localparam int SCALE_W       = 8;
  localparam int HALF_W        = 5;   // signed element in half units, -12..12
  localparam int PROD_W        = 9;   // signed product in quarter units, -144..144
  localparam int MAX_PROD      = 144;
  localparam int FP_W          = 32;
  localparam int SIG_W         = 24;
  localparam int MXDOT_LATENCY = 2;
  localparam logic [FP_W-1:0] QNAN = 32'h7FC0_0000;

  // Exact value of a 4-bit element in units of 0.5
  function automatic logic signed [HALF_W-1:0] elem_half_units(input logic [ELEM_W-1:0] c);
    logic [HALF_W-1:0] mag;
    if (c[2:1] == 2'b00) mag = {4'b0000, c[0]};
    else                 mag = {3'b001, c[0], 1'b0} << (c[2:1] - 2'd1) >> 1;
    return c[3] ? -$signed(mag) : $signed(mag);
  endfunction
endpackage

// File: rtl/mxdot_products.sv
module mxdot_products
  import mxdot_pkg::*;
#(
  parameter int N_ELEM = 32
) (
  input  logic [N_ELEM*ELEM_W-1:0] a_elems,
  input  logic [N_ELEM*ELEM_W-1:0] b_elems,
  output logic [N_ELEM*PROD_W-1:0] prods
);
  for (genvar i = 0; i < N_ELEM; i++) begin : g_lane
    logic signed [HALF_W-1:0] ha, hb;
    logic signed [PROD_W-1:0] p;
    always_comb begin
      ha = elem_half_units(a_elems[i*ELEM_W +: ELEM_W]);
      hb = elem_half_units(b_elems[i*ELEM_W +: ELEM_W]);
      p  = PROD_W'(ha) * PROD_W'(hb);
    end
    assign prods[i*PROD_W +: PROD_W] = p;
  end
endmodule

// File: rtl/mxdot_sum.sv
module mxdot_sum
  import mxdot_pkg::*;
#(
  parameter int N_ELEM = 32,
  parameter int ACC_W  = 16
) (
  input  logic [N_ELEM*PROD_W-1:0] prods,
  output logic signed [ACC_W-1:0] acc
);
  always_comb begin
    acc = '0;
    for (int i = 0; i < N_ELEM; i++)
      acc = acc + ACC_W'($signed(prods[i*PROD_W +: PROD_W]));
  end
endmodule

// File: rtl/mxdot_to_fp32.sv
module mxdot_to_fp32
  import mxdot_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic signed [ACC_W-1:0] acc,
  input  logic [SCALE_W-1:0]      sa,
  input  logic [SCALE_W-1:0]      sb,
  output logic [FP_W-1:0]         result
);
  localparam int EXP_BIAS_ADJ = 129; // 2*127 + 2 (quarter units) - 127 (FP32 bias)

  logic              sgn;
  logic [ACC_W-1:0]  mag;
  logic [SIG_W-1:0]  norm;
  int                msb;
  int                e_biased;

  always_comb begin
    sgn = acc[ACC_W-1];
    mag = sgn ? ACC_W'(-acc) : ACC_W'(acc);
    msb = 0;
    for (int i = 0; i < ACC_W; i++)
      if (mag[i]) msb = i;
    e_biased = msb + int'(sa) + int'(sb) - EXP_BIAS_ADJ;
    norm = SIG_W'(mag) << (SIG_W - 1 - msb);
    if (sa == '1 || sb == '1)      result = QNAN;
    else if (mag == '0)            result = '0;
    else if (e_biased >= 255)      result = {sgn, 8'hFF, 23'd0};
    else if (e_biased <= 0)        result = {sgn, 31'd0};
    else                           result = {sgn, e_biased[7:0], norm[SIG_W-2:0]};
  end
endmodule

// File: rtl/mxdot_block.sv
module mxdot_block
  import mxdot_pkg::*;
#(
  parameter int N_ELEM = 32,
  parameter int ACC_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_ELEM*ELEM_W-1:0] a_elems,
  input  logic [SCALE_W-1:0]       a_scale,
  input  logic [N_ELEM*ELEM_W-1:0] b_elems,
  input  logic [SCALE_W-1:0]       b_scale,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [FP_W-1:0]          out_result
);
  localparam int ACC_LIMIT = N_ELEM * MAX_PROD;

  initial begin
    if (ACC_W > SIG_W || (1 << (ACC_W - 1)) <= ACC_LIMIT)
      $error("ACC_W must hold the exact sum and fit the FP32 significand");
  end

  logic [N_ELEM*PROD_W-1:0] prods;
  logic signed [ACC_W-1:0]  acc_c;
  logic                     advance;
  logic                     s1_v;
  logic signed [ACC_W-1:0]  s1_acc;
  logic [SCALE_W-1:0]       s1_sa, s1_sb;
  logic [FP_W-1:0]          fp_c;

  mxdot_products #(.N_ELEM(N_ELEM)) u_prod (
    .a_elems(a_elems), .b_elems(b_elems), .prods(prods));

  mxdot_sum #(.N_ELEM(N_ELEM), .ACC_W(ACC_W)) u_sum (
    .prods(prods), .acc(acc_c));

  mxdot_to_fp32 #(.ACC_W(ACC_W)) u_cvt (
    .acc(s1_acc), .sa(s1_sa), .sb(s1_sb), .result(fp_c));

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      s1_v      <= in_valid;
      out_valid <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      if (in_valid) begin
        s1_acc <= acc_c;
        s1_sa  <= a_scale;
        s1_sb  <= b_scale;
      end
      if (s1_v) out_result <= fp_c;
    end
  end

  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    s1_v |-> (s1_acc <= ACC_W'(ACC_LIMIT) && s1_acc >= -ACC_W'(ACC_LIMIT)));

  // R4
  nan_prop_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && s1_v && (s1_sa == 8'hFF || s1_sb == 8'hFF)) |=> (out_result == QNAN));

  // R6
  canon_special_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_result[30:23] == 8'hFF) |-> (out_result[22:0] == 23'd0 || out_result == QNAN));

  // R7
  no_subnormal_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_result[30:23] == 8'h00) |-> (out_result[22:0] == 23'd0));

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/tb_mxdot_block.sv
`timescale 1ns/1ps
module tb_mxdot_block;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] a_elems = '0;
  logic [7:0]   a_scale = 8'd127;
  logic [127:0] b_elems = '0;
  logic [7:0]   b_scale = 8'd127;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mxdot_block dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a_elems(a_elems), .a_scale(a_scale), .b_elems(b_elems), .b_scale(b_scale),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic int half_val(input logic [3:0] c);
    int m;
    case (c[2:0])
      3'd0: m = 0;  3'd1: m = 1;  3'd2: m = 2;  3'd3: m = 3;
      3'd4: m = 4;  3'd5: m = 6;  3'd6: m = 8;  default: m = 12;
    endcase
    return c[3] ? -m : m;
  endfunction

  function automatic logic [31:0] model(input logic [127:0] a, input logic [7:0] sa,
                                        input logic [127:0] b, input logic [7:0] sb);
    int s, mag, p, e;
    logic sg;
    logic [31:0] sh;
    if (sa == 8'hFF || sb == 8'hFF) return 32'h7FC00000;
    s = 0;
    for (int i = 0; i < 32; i++) s += half_val(a[4*i +: 4]) * half_val(b[4*i +: 4]);
    if (s == 0) return 32'h0;
    sg = (s < 0);
    mag = sg ? -s : s;
    p = 0;
    for (int i = 0; i < 31; i++) if ((mag >> i) & 1) p = i;
    e = p + int'(sa) - 127 + int'(sb) - 127 - 2 + 127;
    if (e >= 255) return {sg, 8'hFF, 23'd0};
    if (e <= 0) return {sg, 31'd0};
    sh = 32'(mag) << (23 - p);
    return {sg, e[7:0], sh[22:0]};
  endfunction

  // drive one pair, check latency 2 and the value
  task automatic run_one(input string req, input logic [127:0] a, input logic [7:0] sa,
                         input logic [127:0] b, input logic [7:0] sb, input logic [31:0] exp);
    @(negedge clk);
    a_elems = a; a_scale = sa; b_elems = b; b_scale = sb; in_valid = 1'b1;
    check({req, " in_ready"}, {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R8 not yet valid"}, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check({req, " R8 valid at latency"}, {31'd0, out_valid}, 32'd1);
    check(req, out_result, exp);
    check({req, " model"}, model(a, sa, b, sb), exp);
  endtask

  function automatic logic [127:0] fill(input logic [3:0] c);
    logic [127:0] v;
    for (int i = 0; i < 32; i++) v[4*i +: 4] = c;
    return v;
  endfunction

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 idle after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic test_basic();
    // 32 * (1.0*1.0) = 32.0
    run_one("R2 ones", fill(4'h2), 8'd127, fill(4'h2), 8'd127, 32'h42000000);
    // 32 * (6 * -0.5) = -96 -> scale 2^1*2^0 -> -192
    run_one("R1 R3 mixed", fill(4'h7), 8'd128, fill(4'h9), 8'd127, 32'hC3400000);
    // negative zero codes read as zero
    run_one("R1 negzero", fill(4'h8), 8'd127, fill(4'h7), 8'd127, 32'h0);
  endtask

  task automatic test_random();
    logic [127:0] a, b;
    logic [7:0] sa, sb;
    for (int t = 0; t < 24; t++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      sa = 8'(90 + ($urandom % 70));
      sb = 8'(90 + ($urandom % 70));
      run_one("R2 R3 random", a, sa, b, sb, model(a, sa, b, sb));
    end
  endtask

  task automatic test_specials();
    run_one("R4 nan a", fill(4'h2), 8'hFF, fill(4'h2), 8'd127, 32'h7FC00000);
    run_one("R4 nan b zero elems", '0, 8'd3, '0, 8'hFF, 32'h7FC00000);
    // +1*+1 and -1*+1 cancel
    run_one("R5 cancel", {120'd0, 4'hA, 4'h2}, 8'd127, {120'd0, 4'h2, 4'h2}, 8'd127, 32'h0);
    run_one("R6 overflow pos", fill(4'h7), 8'd254, fill(4'h7), 8'd254, 32'h7F800000);
    run_one("R6 overflow neg", fill(4'hF), 8'd254, fill(4'h7), 8'd254, 32'hFF800000);
    run_one("R6 edge 254", {124'd0, 4'h1}, 8'd254, {124'd0, 4'h1}, 8'd129, 32'h7F000000);
    run_one("R6 edge 255", {124'd0, 4'h1}, 8'd254, {124'd0, 4'h1}, 8'd130, 32'h7F800000);
    run_one("R7 underflow pos", {124'd0, 4'h1}, 8'd0, {124'd0, 4'h1}, 8'd0, 32'h0);
    run_one("R7 underflow neg", {124'd0, 4'h9}, 8'd64, {124'd0, 4'h1}, 8'd65, 32'h80000000);
    run_one("R7 min normal", {124'd0, 4'h1}, 8'd65, {124'd0, 4'h1}, 8'd65, 32'h00800000);
  endtask

  task automatic test_stall();
    logic [31:0] exp [3];
    exp[0] = 32'h42000000;
    exp[1] = model(fill(4'h3), 8'd120, fill(4'hC), 8'd130);
    exp[2] = model(fill(4'h6), 8'd127, fill(4'h5), 8'd100);
    @(negedge clk);
    out_ready = 1'b0;
    a_elems = fill(4'h2); a_scale = 8'd127; b_elems = fill(4'h2); b_scale = 8'd127;
    in_valid = 1'b1;
    @(negedge clk);
    a_elems = fill(4'h3); a_scale = 8'd120; b_elems = fill(4'hC); b_scale = 8'd130;
    @(negedge clk);
    a_elems = fill(4'h6); a_scale = 8'd127; b_elems = fill(4'h5); b_scale = 8'd100;
    for (int c = 0; c < 3; c++) begin
      check("R9 full in_ready low", {31'd0, in_ready}, 32'd0);
      check("R9 held result", out_result, exp[0]);
      check("R9 held valid", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
    end
    begin
      int idx = 0;
      for (int c = 0; c < 6; c++) begin
        if (c == 0) out_ready = 1'b1;
        if (c == 1) in_valid = 1'b0;
        if (out_valid && idx < 3) begin
          check("R9 order", out_result, exp[idx]);
          idx++;
        end
        @(negedge clk);
      end
      check("R9 count drained", 32'(idx), 32'd3);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    test_reset();
    test_basic();
    test_specials();
    test_random();
    test_stall();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule